// File: doc/BRIEF.md
# External Trigger Conditioner with Level Capture

This block takes a group of asynchronous trigger pins bound for a data-acquisition engine and turns them into one clean, single-cycle trigger event. Each pin is brought into the clock domain through a synchronizer chain. A per-pin configuration bit then inverts it or passes it through. A rising edge of the result counts as the active edge. With the inversion bit set, the acquisition therefore starts on a falling edge of the raw pin.

A one-cycle arm strobe lets the block accept exactly one trigger. Once a trigger is accepted, the block disarms itself and raises its event output for one cycle. In that same cycle it snapshots the conditioned level of every pin, plus a mask of the pins whose edge caused the event. Because the snapshot is taken after inversion, any pin that started the acquisition always reads back as 1. The snapshot holds until the next accepted trigger replaces it.

Top module: `trig_cond_top`

## Requirements
- R1: While rst_ni is low, trig_o, armed_o, trig_src_o and cap_level_o are all 0.
- R2: Each raw pin passes through SYNC_STAGES flops. An active edge on a pin of an armed block drives trig_o high after the (SYNC_STAGES+1)-th rising clock edge that follows the pin change.
- R3: The conditioned level of pin i is trig_raw_i[i] XOR pol_inv_i[i]. With pol_inv_i[i]=0 the raw rising edge is active; with pol_inv_i[i]=1 the raw falling edge is active.
- R4: trig_o is high for exactly one cycle per accepted trigger. It is raised only if armed_o was high in the cycle in which the active edge was detected.
- R5: After an accepted trigger, armed_o goes low and active edges are ignored (trig_o stays 0, and cap_level_o and trig_src_o are unchanged) until arm_i is pulsed again.
- R6: In the cycle trig_o is high, cap_level_o[i] holds the conditioned level of pin i, and trig_src_o[i] is 1 exactly for the pins whose active edge caused the trigger. Every pin flagged in trig_src_o reads 1 in cap_level_o.
- R7: cap_level_o and trig_src_o change only in a cycle in which trig_o is high.
- R8: A high arm_i sets armed_o from the next cycle onward. If arm_i is high in the same cycle that a trigger is accepted, armed_o stays high.
- R9: No trigger arises from levels present at reset release. Edge detection starts only after SYNC_STAGES+1 clock edges out of reset, so an inverted idle-low pin does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_raw_i | input | N_TRIG | Raw asynchronous trigger pins |
| pol_inv_i | input | N_TRIG | Per-pin inversion select (1 = falling edge active) |
| arm_i | input | 1 | Arm strobe |
| trig_o | output | 1 | One-cycle accepted trigger event |
| armed_o | output | 1 | Block is waiting for a trigger |
| trig_src_o | output | N_TRIG | Pins whose active edge caused the last trigger |
| cap_level_o | output | N_TRIG | Conditioned levels snapshotted at the last trigger |

## Verification
The bench builds the block with N_TRIG=3 and SYNC_STAGES=2. A third pin allows simultaneous edges on two pins while another pin sits at a different level, so the mask and snapshot can disagree in the ways R6 allows. With a two-flop chain, the three-cycle latency and the reset blanking window are short enough to be hit by directed cases. Random pin toggles, polarity flips and arm strobes then reach the arm-during-fire and edge-while-disarmed orderings many times.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic {
    ARM_IDLE  = 1'b0,
    ARM_READY = 1'b1
  } arm_state_e;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int N_TRIG      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TRIG-1:0] d_i,
  output logic [N_TRIG-1:0] q_o
);
  logic [N_TRIG-1:0] stage_q [SYNC_STAGES];

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/trig_edge.sv
module trig_edge #(
  parameter int N_TRIG      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TRIG-1:0] sync_i,
  input  logic [N_TRIG-1:0] pol_i,
  output logic [N_TRIG-1:0] level_o,
  output logic [N_TRIG-1:0] rise_o
);
  localparam int BLANK = SYNC_STAGES + 1;
  localparam int CNT_W = $clog2(BLANK + 1);

  logic [N_TRIG-1:0] prev_q;
  logic [CNT_W-1:0]  blank_q;
  logic              valid;

  assign valid = (blank_q == CNT_W'(BLANK));

  // blank until the sync chain and prev_q hold real samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    blank_q <= '0;
    else if (!valid) blank_q <= blank_q + 1'b1;
  end

  for (genvar i = 0; i < N_TRIG; i++) begin : g_bit
    assign level_o[i] = sync_i[i] ^ pol_i[i];
    assign rise_o[i]  = valid & level_o[i] & ~prev_q[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[i] <= 1'b0;
      else         prev_q[i] <= level_o[i];
    end
  end

  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o & $past(rise_o)) == '0); // R4
endmodule

// File: rtl/trig_arm_ctrl.sv
module trig_arm_ctrl
  import trig_pkg::*;
#(
  parameter int N_TRIG = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [N_TRIG-1:0] level_i,
  input  logic [N_TRIG-1:0] rise_i,
  output logic              trig_o,
  output logic              armed_o,
  output logic [N_TRIG-1:0] src_o,
  output logic [N_TRIG-1:0] cap_o
);
  arm_state_e        state_q, state_d;
  logic              fire;
  logic              trig_q;
  logic [N_TRIG-1:0] src_q, cap_q;

  assign fire = (state_q == ARM_READY) && (|rise_i);

  always_comb begin
    state_d = state_q;
    if (fire)  state_d = ARM_IDLE;
    if (arm_i) state_d = ARM_READY;   // re-arm wins over disarm
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ARM_IDLE;
      trig_q  <= 1'b0;
      src_q   <= '0;
      cap_q   <= '0;
    end else begin
      state_q <= state_d;
      trig_q  <= fire;
      if (fire) begin
        src_q <= rise_i;
        cap_q <= level_i;
      end
    end
  end

  assign trig_o  = trig_q;
  assign armed_o = (state_q == ARM_READY);
  assign src_o   = src_q;
  assign cap_o   = cap_q;

  AST_FIRE_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> $past(armed_o)); // R4
  AST_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_o && !$past(arm_i)) |-> !armed_o); // R5
  AST_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> armed_o); // R8
endmodule

// File: rtl/trig_cond_top.sv
module trig_cond_top #(
  parameter int N_TRIG      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TRIG-1:0] trig_raw_i,
  input  logic [N_TRIG-1:0] pol_inv_i,
  input  logic              arm_i,
  output logic              trig_o,
  output logic              armed_o,
  output logic [N_TRIG-1:0] trig_src_o,
  output logic [N_TRIG-1:0] cap_level_o
);
  logic [N_TRIG-1:0] sync_w, level_w, rise_w;

  trig_sync #(.N_TRIG(N_TRIG), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (trig_raw_i),
    .q_o   (sync_w)
  );

  trig_edge #(.N_TRIG(N_TRIG), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_w),
    .pol_i  (pol_inv_i),
    .level_o(level_w),
    .rise_o (rise_w)
  );

  trig_arm_ctrl #(.N_TRIG(N_TRIG)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm_i),
    .level_i(level_w),
    .rise_i (rise_w),
    .trig_o (trig_o),
    .armed_o(armed_o),
    .src_o  (trig_src_o),
    .cap_o  (cap_level_o)
  );

  AST_SRC_READS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> ((trig_src_o != '0) && ((cap_level_o & trig_src_o) == trig_src_o))); // R6
  AST_CAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_o |-> ($stable(cap_level_o) && $stable(trig_src_o))); // R7
endmodule

// File: tb/trig_cond_top_test.sv
module trig_cond_top_test;
  localparam int N  = 3;
  localparam int SS = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] raw_i = '0, pol_i = '0;
  logic         arm_i = 1'b0;
  logic         trig_o, armed_o;
  logic [N-1:0] src_o, cap_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  trig_cond_top #(.N_TRIG(N), .SYNC_STAGES(SS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .trig_raw_i(raw_i), .pol_inv_i(pol_i),
    .arm_i(arm_i), .trig_o(trig_o), .armed_o(armed_o),
    .trig_src_o(src_o), .cap_level_o(cap_o)
  );

  // reference state built from the requirements
  logic [N-1:0] m_sync [SS];
  logic [N-1:0] m_prev, m_src, m_cap;
  logic         m_trig, m_armed;
  int           m_edges;

  function automatic logic [N-1:0] cond_of(logic [N-1:0] s, logic [N-1:0] p);
    return s ^ p;                                    // R3
  endfunction

  function automatic logic [N-1:0] rise_of(logic [N-1:0] c, logic [N-1:0] p, int e);
    return (e >= SS + 1) ? (c & ~p) : '0;            // R9
  endfunction

  task automatic model_reset();
    for (int s = 0; s < SS; s++) m_sync[s] = '0;
    m_prev = '0; m_src = '0; m_cap = '0;
    m_trig = 0; m_armed = 0; m_edges = 0;
  endtask

  task automatic model_edge();
    logic [N-1:0] c, r;
    logic f;
    c = cond_of(m_sync[SS-1], pol_i);
    r = rise_of(c, m_prev, m_edges);
    f = m_armed && (|r);
    m_trig = f;
    if (f) begin m_src = r; m_cap = c; end
    m_armed = arm_i ? 1'b1 : (f ? 1'b0 : m_armed);
    m_prev = c;
    for (int s = SS - 1; s > 0; s--) m_sync[s] = m_sync[s-1];
    m_sync[0] = raw_i;
    if (m_edges < SS + 1) m_edges++;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R4 trig_o", 32'(trig_o), 32'(m_trig));
    chk("R5 armed_o", 32'(armed_o), 32'(m_armed));
    chk("R6 cap_level_o", 32'(cap_o), 32'(m_cap));
    chk("R6 trig_src_o", 32'(src_o), 32'(m_src));
    if (trig_o) chk("R6 src reads one", 32'(cap_o & src_o), 32'(src_o));
  endtask

  // drive at negedge, step model at posedge, compare at next negedge
  task automatic cyc(logic [N-1:0] raw, logic [N-1:0] pol, logic arm);
    raw_i = raw; pol_i = pol; arm_i = arm;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seen, lat;
    logic [N-1:0] r, p;
    void'($urandom(32'h5eed_0042));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 trig_o", 32'(trig_o), 0);
    chk("R1 armed_o", 32'(armed_o), 0);
    chk("R1 src", 32'(src_o), 0);
    chk("R1 cap", 32'(cap_o), 0);
    rst_n = 1'b1;

    // R9: inverted idle-low pins must not fire after reset
    seen = 0;
    pol_i = 3'b101;
    cyc('0, 3'b101, 1'b1);
    for (int k = 0; k < 8; k++) begin cyc('0, 3'b101, 1'b0); if (trig_o) seen++; end
    chk("R9 no reset trigger", 32'(seen), 0);
    chk("R8 armed after strobe", 32'(armed_o), 1);

    // R3/R2: pin0 inverted -> falling raw edge fires, latency SS+1
    for (int k = 0; k < 5; k++) cyc(3'b001, 3'b101, 1'b0);
    chk("R3 rising raw ignored when inverted", 32'(armed_o), 1);
    lat = 0;
    for (int k = 1; k <= 6; k++) begin
      cyc(3'b000, 3'b101, 1'b0);
      if (trig_o && lat == 0) lat = k;
    end
    chk("R2 latency", 32'(lat), 32'(SS + 1));
    chk("R5 disarmed", 32'(armed_o), 0);

    // R5: edge while disarmed is ignored
    for (int k = 0; k < 6; k++) cyc(3'b010, 3'b101, 1'b0);
    chk("R5 cap unchanged", 32'(cap_o), 32'(3'b001 ^ 3'b000 ^ 3'b100));

    // R8: arm in the fire cycle keeps it armed; pin1 non-inverted rising
    cyc(3'b000, 3'b101, 1'b1);
    for (int k = 0; k < 5; k++) cyc(3'b000, 3'b101, 1'b0);
    cyc(3'b010, 3'b101, 1'b0);
    cyc(3'b010, 3'b101, 1'b0);
    cyc(3'b010, 3'b101, 1'b1);
    chk("R8 fire seen", 32'(trig_o), 1);
    chk("R8 stays armed", 32'(armed_o), 1);
    chk("R6 src pin1", 32'(src_o), 32'(3'b010));

    // random phase
    r = 3'b010; p = 3'b101;
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 3) == 0) r = r ^ N'($urandom_range(1, (1 << N) - 1));
      if ($urandom_range(0, 63) == 0) p = p ^ N'($urandom_range(1, (1 << N) - 1));
      cyc(r, p, $urandom_range(0, 7) == 0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule